// File: doc/BRIEF.md
# Hash Engine Command-Sequence Checker

This block sits beside a sponge-based hash and message-authentication engine and checks every command that software issues to it. It follows the engine through six phases: idle, message feed, processing, absorbed, squeezing and a terminal error phase. For each phase it knows which commands are legal. An illegal command is blocked, so the tracked phase does not move. An error code is reported one cycle later.

When a message starts, the checker also checks the configuration. It checks that the hash mode and strength pair is supported. When the MAC function is enabled, it checks that the 6-byte customization prefix holds the required encoded function name, and that entropy has been marked ready. Several errors can occur in the same cycle; only the one with the highest priority is reported.

An escalation input forces the terminal error phase. A strictly-true clear request returns the checker to idle.

Top module: `hash_cmd_checker`

## Requirements
- R1: After the active-low asynchronous reset, `phase` is 0 (idle) and `errValid` is 0.
- R2: Phase codes are idle=0, feed=1, processing=2, absorbed=3, squeezing=4, terminal=5. Command codes are none=0, start=1, process=2, manual-run=3, done=4; codes 5 to 7 are legal in no state. The legal path is:
  - start moves idle to feed;
  - process moves feed to processing;
  - manual-run moves absorbed to squeezing;
  - `permDone` moves squeezing back to absorbed;
  - done moves absorbed to idle.
- R3: A start command while `appActive` is high leaves the phase in idle and raises no error.
- R4: The legal commands in each phase are:
  - idle: none or start;
  - feed: none or process;
  - processing: none only;
  - absorbed: none, manual-run or done;
  - squeezing: none only.

  Any other command raises error code 0 (sequence) and the phase holds. In the terminal phase no command raises an error.
- R5: Processing moves to absorbed only when `absorbedFlag` equals exactly 4'b0110. Any other value, including 4'b0111, leaves the phase in processing.
- R6: On an accepted start, the mode and strength pair must be one of the supported pairs:
  - mode 0 (fixed-length hash) with strength 1, 2, 3 or 4 (224, 256, 384 or 512);
  - mode 2 or mode 3 (extendable output) with strength 0 or 2 (128 or 256).

  Any other pair raises code 1. If `allowUnsupported` is 0, the start is blocked and the phase stays idle. If `allowUnsupported` is 1, the phase moves to feed.
- R7: On a start with `macEn` high, `custPrefix` must equal 48'h43414D4B2001. The low byte is sent first. Any other value raises code 2, and the start is not blocked.
- R8: An `entropyPulse` sets a sticky ready flag, but only while the phase is idle; a pulse in any other phase is ignored. `errProcessed` clears the flag. A start with `macEn` high while the flag is clear raises code 3 and is blocked.
- R9: When several errors occur in the same cycle, only one is reported, by priority: sequence (0) over mode/strength (1) over prefix (2) over entropy (3).
- R10: `errValid` and `errCode` are registered. They appear in the cycle after the offending command and last exactly one cycle.
- R11: `escalate` forces `phase` to 5 on the next edge, whatever the command. The phase stays at 5 until a clear request arrives.
- R12: A `clearAfterErr` equal to exactly 4'b0110 while `escalate` is low forces the next phase to idle from any phase. A clear that arrives together with `escalate` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swCmd | input | 3 | Software command code |
| appActive | input | 1 | Hardware application interface is using the engine |
| hashMode | input | 2 | Hash mode selection |
| hashStrength | input | 3 | Security strength selection |
| macEn | input | 1 | MAC function enabled |
| custPrefix | input | 48 | 6-byte customization prefix |
| allowUnsupported | input | 1 | Allow unsupported mode/strength pairs to proceed |
| entropyPulse | input | 1 | Entropy became ready |
| errProcessed | input | 1 | Software has handled the error; clears the entropy flag |
| absorbedFlag | input | 4 | Multi-bit absorbed status |
| permDone | input | 1 | Permutation finished |
| escalate | input | 1 | Escalation request |
| clearAfterErr | input | 4 | Multi-bit clear request |
| phase | output | 3 | Tracked engine phase |
| errValid | output | 1 | One-cycle error strobe |
| errCode | output | 2 | Reported error code |

## Verification
Every result here is due one clock edge after the stimulus that causes it. This covers a phase change, a held phase, `errValid` with its code, and the setting or clearing of the entropy flag.

The bench drives each stimulus on a falling edge and samples on the next falling edge, half a cycle after the capturing edge. It then samples one more cycle to confirm that the strobe has dropped.

The entropy flag cannot be observed directly. The bench therefore checks it in the cycle that follows, through whether a MAC start reports code 3.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  localparam int CmdW = 3;
  localparam int PhaseW = 3;
  localparam int MuW = 4;
  localparam int CodeW = 2;

  localparam logic [CmdW-1:0] CmdNone    = 3'd0;
  localparam logic [CmdW-1:0] CmdStart   = 3'd1;
  localparam logic [CmdW-1:0] CmdProcess = 3'd2;
  localparam logic [CmdW-1:0] CmdManual  = 3'd3;
  localparam logic [CmdW-1:0] CmdDone    = 3'd4;

  localparam logic [MuW-1:0] MuTrue = 4'b0110;

  localparam logic [1:0] ModeFixed = 2'd0;
  localparam logic [1:0] ModeXof   = 2'd2;
  localparam logic [1:0] ModeCxof  = 2'd3;

  localparam logic [2:0] Str128 = 3'd0;
  localparam logic [2:0] Str224 = 3'd1;
  localparam logic [2:0] Str256 = 3'd2;
  localparam logic [2:0] Str384 = 3'd3;
  localparam logic [2:0] Str512 = 3'd4;

  localparam logic [CodeW-1:0] ErrSeq    = 2'd0;
  localparam logic [CodeW-1:0] ErrMode   = 2'd1;
  localparam logic [CodeW-1:0] ErrPrefix = 2'd2;
  localparam logic [CodeW-1:0] ErrEntr   = 2'd3;

  typedef enum logic [PhaseW-1:0] {
    PhIdle    = 3'd0,
    PhFeed    = 3'd1,
    PhProc    = 3'd2,
    PhAbsorb  = 3'd3,
    PhSqueeze = 3'd4,
    PhTerm    = 3'd5
  } phase_e;

  typedef struct packed {
    logic inIdle;
    logic startEdge;
    logic seqErr;
  } ctrl_strb_t;
endpackage

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import hseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CmdW-1:0]     swCmd,
  input  logic                appActive,
  input  logic [MuW-1:0]      absorbedFlag,
  input  logic                permDone,
  input  logic                escalate,
  input  logic [MuW-1:0]      clearReq,
  input  logic                blockCmd,
  output phase_e              phase,
  output ctrl_strb_t          strb
);
  phase_e phaseQ;
  phase_e rawNext;
  phase_e phaseD;
  logic   cmdLegal;
  logic   clearTrue;

  assign clearTrue = (clearReq == MuTrue);

  always_comb begin
    cmdLegal = 1'b1;
    rawNext  = phaseQ;
    unique case (phaseQ)
      PhIdle: begin
        cmdLegal = swCmd inside {CmdNone, CmdStart};
        if (swCmd == CmdStart && !appActive) rawNext = PhFeed;
      end
      PhFeed: begin
        cmdLegal = swCmd inside {CmdNone, CmdProcess};
        if (swCmd == CmdProcess) rawNext = PhProc;
      end
      PhProc: begin
        cmdLegal = (swCmd == CmdNone);
        if (absorbedFlag == MuTrue) rawNext = PhAbsorb;
      end
      PhAbsorb: begin
        cmdLegal = swCmd inside {CmdNone, CmdManual, CmdDone};
        if (swCmd == CmdManual)    rawNext = PhSqueeze;
        else if (swCmd == CmdDone) rawNext = PhIdle;
      end
      PhSqueeze: begin
        cmdLegal = (swCmd == CmdNone);
        if (permDone) rawNext = PhAbsorb;
      end
      default: begin
        cmdLegal = 1'b1;
        rawNext  = PhTerm;
      end
    endcase
  end

  always_comb begin
    strb.inIdle    = (phaseQ == PhIdle);
    strb.startEdge = (phaseQ == PhIdle) && (rawNext == PhFeed);
    strb.seqErr    = !cmdLegal;
  end

  always_comb begin
    if (escalate)       phaseD = PhTerm;
    else if (clearTrue) phaseD = PhIdle;
    else if (blockCmd)  phaseD = phaseQ;
    else                phaseD = rawNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= PhIdle;
    else       phaseQ <= phaseD;
  end

  assign phase = phaseQ;

  a_r11_escalate_term: assert property (@(posedge clk) disable iff (!rstN)
    escalate |=> phaseQ == PhTerm);
  a_r4_block_holds: assert property (@(posedge clk) disable iff (!rstN)
    (blockCmd && !escalate && clearReq != MuTrue) |=> $stable(phaseQ));
  a_r11_term_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PhTerm && clearReq != MuTrue) |=> phaseQ == PhTerm);
  a_r12_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq == MuTrue && !escalate) |=> phaseQ == PhIdle);
endmodule

// File: rtl/hseq_dp.sv
module hseq_dp
  import hseq_pkg::*;
#(
  parameter int PrefixW = 48,
  parameter logic [PrefixW-1:0] MacPrefix = 48'h43414D4B2001
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strb_t         strb,
  input  logic [1:0]         hashMode,
  input  logic [2:0]         hashStrength,
  input  logic               macEn,
  input  logic [PrefixW-1:0] custPrefix,
  input  logic               allowUnsupported,
  input  logic               entropyPulse,
  input  logic               errProcessed,
  output logic               blockCmd,
  output logic               errValid,
  output logic [CodeW-1:0]   errCode
);
  logic entReady;
  logic modeOk;
  logic modeErr;
  logic prefixErr;
  logic entErr;
  logic anyErr;
  logic [CodeW-1:0] codeD;
  logic errValidQ;
  logic [CodeW-1:0] errCodeQ;

  always_comb begin
    modeOk = ((hashMode == ModeFixed) &&
              (hashStrength inside {Str224, Str256, Str384, Str512})) ||
             (((hashMode == ModeXof) || (hashMode == ModeCxof)) &&
              (hashStrength inside {Str128, Str256}));
    modeErr   = strb.startEdge && !modeOk;
    prefixErr = strb.startEdge && macEn && (custPrefix != MacPrefix);
    entErr    = strb.startEdge && macEn && !entReady;
    anyErr    = strb.seqErr || modeErr || prefixErr || entErr;
    blockCmd  = strb.seqErr || (modeErr && !allowUnsupported) || entErr;
  end

  always_comb begin
    if (strb.seqErr)   codeD = ErrSeq;
    else if (modeErr)  codeD = ErrMode;
    else if (prefixErr) codeD = ErrPrefix;
    else               codeD = ErrEntr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            entReady <= 1'b0;
    else if (errProcessed)                entReady <= 1'b0;
    else if (entropyPulse && strb.inIdle) entReady <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValidQ <= 1'b0;
      errCodeQ  <= ErrSeq;
    end else begin
      errValidQ <= anyErr;
      errCodeQ  <= anyErr ? codeD : ErrSeq;
    end
  end

  assign errValid = errValidQ;
  assign errCode  = errCodeQ;

  a_r9_seq_first: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqErr |=> (errValidQ && errCodeQ == ErrSeq));
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (entropyPulse && strb.inIdle && !errProcessed) |=> entReady);
  a_r8_flag_clr: assert property (@(posedge clk) disable iff (!rstN)
    errProcessed |=> !entReady);
  a_r6_block_mode: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startEdge && !modeOk && !allowUnsupported) |-> blockCmd);
  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rstN)
    !anyErr |=> !errValidQ);
endmodule

// File: rtl/hash_cmd_checker.sv
module hash_cmd_checker
  import hseq_pkg::*;
#(
  parameter int PrefixBytes = 6,
  localparam int PrefixW = PrefixBytes * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         swCmd,
  input  logic               appActive,
  input  logic [1:0]         hashMode,
  input  logic [2:0]         hashStrength,
  input  logic               macEn,
  input  logic [PrefixW-1:0] custPrefix,
  input  logic               allowUnsupported,
  input  logic               entropyPulse,
  input  logic               errProcessed,
  input  logic [3:0]         absorbedFlag,
  input  logic               permDone,
  input  logic               escalate,
  input  logic [3:0]         clearAfterErr,
  output logic [2:0]         phase,
  output logic               errValid,
  output logic [1:0]         errCode
);
  ctrl_strb_t strb;
  logic       blockCmd;
  phase_e     phaseInt;

  hseq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .swCmd        (swCmd),
    .appActive    (appActive),
    .absorbedFlag (absorbedFlag),
    .permDone     (permDone),
    .escalate     (escalate),
    .clearReq     (clearAfterErr),
    .blockCmd     (blockCmd),
    .phase        (phaseInt),
    .strb         (strb)
  );

  hseq_dp #(
    .PrefixW   (PrefixW),
    .MacPrefix (PrefixW'(48'h43414D4B2001))
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strb             (strb),
    .hashMode         (hashMode),
    .hashStrength     (hashStrength),
    .macEn            (macEn),
    .custPrefix       (custPrefix),
    .allowUnsupported (allowUnsupported),
    .entropyPulse     (entropyPulse),
    .errProcessed     (errProcessed),
    .blockCmd         (blockCmd),
    .errValid         (errValid),
    .errCode          (errCode)
  );

  assign phase = phaseInt;
endmodule

// File: tb/hash_cmd_checker_tb_top.sv
`timescale 1ns/1ps
module hash_cmd_checker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] swCmd = 3'd0;
  logic appActive = 1'b0;
  logic [1:0] hashMode = 2'd0;
  logic [2:0] hashStrength = 3'd2;
  logic macEn = 1'b0;
  logic [47:0] custPrefix = 48'h43414D4B2001;
  logic allowUnsupported = 1'b0;
  logic entropyPulse = 1'b0;
  logic errProcessed = 1'b0;
  logic [3:0] absorbedFlag = 4'b1001;
  logic permDone = 1'b0;
  logic escalate = 1'b0;
  logic [3:0] clearAfterErr = 4'b1001;
  logic [2:0] phase;
  logic errValid;
  logic [1:0] errCode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [47:0] GoodPrefix = 48'h43414D4B2001;

  always #4 clk = ~clk;

  hash_cmd_checker dut_i (
    .clk(clk), .rstN(rstN), .swCmd(swCmd), .appActive(appActive),
    .hashMode(hashMode), .hashStrength(hashStrength), .macEn(macEn),
    .custPrefix(custPrefix), .allowUnsupported(allowUnsupported),
    .entropyPulse(entropyPulse), .errProcessed(errProcessed),
    .absorbedFlag(absorbedFlag), .permDone(permDone), .escalate(escalate),
    .clearAfterErr(clearAfterErr), .phase(phase), .errValid(errValid),
    .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkPhase(input string req, input int exp);
    check(phase == exp[2:0], req, phase, exp);
  endtask

  task automatic chkErr(input string req, input bit v, input int code);
    check(errValid == v, req, errValid, v);
    if (v) check(errCode == code[1:0], req, errCode, code);
  endtask

  // drive for one cycle, then return inputs to idle values
  task automatic stepCmd(input logic [2:0] c);
    swCmd = c;
    @(negedge clk);
    swCmd = 3'd0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
  endtask

  task automatic doClear();
    clearAfterErr = 4'b0110;
    @(negedge clk);
    clearAfterErr = 4'b1001;
  endtask

  task automatic pulseEntropy();
    entropyPulse = 1'b1;
    @(negedge clk);
    entropyPulse = 1'b0;
  endtask

  task automatic testReset();
    chkPhase("R1 reset phase", 0);
    check(errValid == 1'b0, "R1 reset errValid", errValid, 0);
  endtask

  task automatic testNormalFlow();
    hashMode = 2'd0; hashStrength = 3'd2; macEn = 1'b0;
    stepCmd(3'd1); chkPhase("R2 start->feed", 1); chkErr("R2 no err", 0, 0);
    stepCmd(3'd2); chkPhase("R2 process->proc", 2);
    stepCmd(3'd2); chkPhase("R4 proc holds on bad cmd", 2); chkErr("R4 seq code", 1, 0);
    idleCycle(); chkErr("R10 strobe one cycle", 0, 0);
    absorbedFlag = 4'b0111; idleCycle(); chkPhase("R5 non-strict absorbed ignored", 2);
    absorbedFlag = 4'b0110; idleCycle(); absorbedFlag = 4'b1001;
    chkPhase("R5 strict absorbed", 3);
    stepCmd(3'd3); chkPhase("R2 manual->squeeze", 4);
    stepCmd(3'd4); chkPhase("R4 squeeze holds", 4); chkErr("R4 squeeze seq", 1, 0);
    permDone = 1'b1; idleCycle(); permDone = 1'b0;
    chkPhase("R2 permDone->absorbed", 3);
    stepCmd(3'd2); chkPhase("R4 absorbed holds", 3); chkErr("R4 absorbed seq", 1, 0);
    stepCmd(3'd4); chkPhase("R2 done->idle", 0); chkErr("R2 done no err", 0, 0);
  endtask

  task automatic testSeqIdle();
    stepCmd(3'd5); chkPhase("R4 idle illegal code holds", 0); chkErr("R4 idle code5", 1, 0);
    stepCmd(3'd1); stepCmd(3'd3);
    chkPhase("R4 feed holds", 1); chkErr("R4 feed manual", 1, 0);
    doClear(); chkPhase("R12 clear from feed", 0);
  endtask

  task automatic testAppActive();
    appActive = 1'b1;
    stepCmd(3'd1); chkPhase("R3 start blocked by app", 0); chkErr("R3 no err", 0, 0);
    appActive = 1'b0;
  endtask

  task automatic testModeStrength();
    hashMode = 2'd0; hashStrength = 3'd0; allowUnsupported = 1'b0;
    stepCmd(3'd1); chkPhase("R6 bad pair blocked", 0); chkErr("R6 code1", 1, 1);
    hashMode = 2'd2; hashStrength = 3'd4;
    stepCmd(3'd1); chkPhase("R6 xof 512 blocked", 0); chkErr("R6 xof code1", 1, 1);
    hashMode = 2'd1; hashStrength = 3'd2;
    stepCmd(3'd1); chkPhase("R6 reserved mode blocked", 0); chkErr("R6 mode1 code1", 1, 1);
    allowUnsupported = 1'b1;
    stepCmd(3'd1); chkPhase("R6 allowed proceeds", 1); chkErr("R6 still reported", 1, 1);
    allowUnsupported = 1'b0; doClear();
    hashMode = 2'd3; hashStrength = 3'd0;
    stepCmd(3'd1); chkPhase("R6 cxof 128 ok", 1); chkErr("R6 cxof no err", 0, 0);
    doClear();
    hashMode = 2'd0; hashStrength = 3'd4;
  endtask

  task automatic testMac();
    macEn = 1'b1;
    errProcessed = 1'b1; idleCycle(); errProcessed = 1'b0;
    stepCmd(3'd1); chkPhase("R8 no entropy blocked", 0); chkErr("R8 code3", 1, 3);
    pulseEntropy();
    custPrefix = 48'h43414D4B2002;
    stepCmd(3'd1); chkPhase("R7 prefix not blocking", 1); chkErr("R7 code2", 1, 2);
    doClear();
    custPrefix = GoodPrefix;
    stepCmd(3'd1); chkPhase("R8 ready mac start", 1); chkErr("R8 no err", 0, 0);
    doClear();
    errProcessed = 1'b1; idleCycle(); errProcessed = 1'b0;
    macEn = 1'b0; stepCmd(3'd1); chkPhase("R8 non-mac to feed", 1);
    pulseEntropy(); doClear();
    macEn = 1'b1;
    stepCmd(3'd1); chkPhase("R8 pulse outside idle ignored", 0); chkErr("R8 still code3", 1, 3);
    hashStrength = 3'd0; custPrefix = 48'h0;
    stepCmd(3'd1); chkErr("R9 mode over prefix/entropy", 1, 1);
    hashStrength = 3'd4;
    stepCmd(3'd1); chkErr("R9 prefix over entropy", 1, 2);
    chkPhase("R9 entropy still blocks", 0);
    custPrefix = GoodPrefix; macEn = 1'b0;
  endtask

  task automatic testEscalate();
    escalate = 1'b1; clearAfterErr = 4'b0110; swCmd = 3'd1;
    @(negedge clk);
    escalate = 1'b0; clearAfterErr = 4'b1001; swCmd = 3'd0;
    chkPhase("R12 clear ignored with escalate", 5);
    stepCmd(3'd6); chkPhase("R11 term holds", 5); chkErr("R11 no err in term", 0, 0);
    clearAfterErr = 4'b0111; idleCycle(); clearAfterErr = 4'b1001;
    chkPhase("R12 non-strict clear ignored", 5);
    doClear(); chkPhase("R12 clear leaves term", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormalFlow();
    testSeqIdle();
    testAppActive();
    testModeStrength();
    testMac();
    testEscalate();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule